// File: doc/BRIEF.md
# Shared Heap Request Arbiter

This block joins several processor cores, one I/O direct-memory-access master and the memory manager's own collector engine onto one shared path toward heap memory. Each core brings two request ports, one for instruction fetches and one for operand loads and stores. Every port offers a valid/ready request with an address, a write flag and 32-bit write data. A round-robin arbiter picks one port per cycle and forwards its request to the memory bus.

The memory bus is pipelined and full-duplex. A new request can go out in any cycle, even while earlier reads are still waiting for data. Read data comes back in request order on its own channel. Each granted read leaves its port number in a small tag queue. When a response arrives, it is steered to the port at the head of that queue and shown there as a one-cycle pulse. When the tag queue is full, reads are held back but writes still go through.

Top module: `heap_req_arbiter`

## Requirements
- R1: Port numbering is fixed. Core k's fetch port is index 2k and its operand port is index 2k+1. The direct-memory-access port is index 2·NUM_CORES. The collector port is index 2·NUM_CORES+1 and is arbitrated like any other port.
- R2: At most one bit of `req_ready` is high in a cycle, and only for a port whose `req_valid` is high while `mem_req_ready` is high. In that same cycle `mem_req_we`, `mem_req_addr` and `mem_req_wdata` carry that port's fields.
- R3: Arbitration is round-robin. After port g is granted, the next grant goes to the first eligible port found by searching upward from g+1 and wrapping past the top index.
- R4: Requests keep being accepted while earlier reads are outstanding, up to 8 reads awaiting data.
- R5: A port is eligible when it is valid and either writing, or reading with fewer than 8 reads outstanding. With 8 reads outstanding no read is granted, but a valid write is granted.
- R6: A read response goes to the port whose read is oldest among the outstanding ones. That port's `rsp_valid` bit is high for exactly the one cycle after the cycle in which `mem_rsp_valid` is high, and `rsp_rdata` then equals the returned data.
- R7: After reset, no response pulse is shown, no read is outstanding, and the round-robin search starts at port 0.
- R8: While `mem_req_ready` is low, no port is granted and the round-robin position is kept.
- R9: `mem_req_valid` is high exactly when at least one port is eligible under R5.
- R10: A response retiring and a new read being issued in the same cycle both take effect, so the outstanding count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Per-port request valid (NP = 2·NUM_CORES+2) |
| req_ready | output | NP | Per-port grant, asserted in the cycle the request is taken |
| req_we | input | NP | Per-port write flag (1 = write, 0 = read) |
| req_addr | input | NP·ADDR_W | Per-port address, port i in bits [i·ADDR_W +: ADDR_W] |
| req_wdata | input | NP·DATA_W | Per-port write data, port i in bits [i·DATA_W +: DATA_W] |
| rsp_valid | output | NP | One-cycle read-data pulse for the destination port |
| rsp_rdata | output | DATA_W | Read data shared by all ports |
| mem_req_valid | output | 1 | Request present toward memory |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_we | output | 1 | Write flag of the forwarded request |
| mem_req_addr | output | ADDR_W | Address of the forwarded request |
| mem_req_wdata | output | DATA_W | Write data of the forwarded request |
| mem_rsp_valid | input | 1 | Read data returning from memory, in request order |
| mem_rsp_rdata | input | DATA_W | Returned read data |

## Verification
Grants, `mem_req_valid` and the forwarded request fields are combinational. They are due in the same cycle as the inputs that cause them, so the bench drives inputs just after a rising edge and compares them at the falling edge of that cycle. A response is registered once, so the pulse for data returned in cycle c is compared at the falling edge of cycle c+1. The bench holds the expected port and data from cycle c for that comparison. The bench keeps its own count of outstanding reads, updated on the same edges as the design. This lets it predict exactly when reads must be held back, and it finally confirms that the full, write-while-full, pipelined-issue and same-cycle issue-and-retire situations all occurred.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int MAX_PORTS = 64;

  // index of the lowest set bit, -1 when none
  function automatic int lowest_set(input logic [MAX_PORTS-1:0] v);
    int r;
    r = -1;
    for (int i = MAX_PORTS - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // round-robin pick: first requester at or above start, else wrap to lowest
  function automatic int rr_select(input logic [MAX_PORTS-1:0] req, input int start);
    logic [MAX_PORTS-1:0] upper;
    upper = req & ~((64'd1 << start) - 64'd1);
    if (upper != '0) return lowest_set(upper);
    return lowest_set(req);
  endfunction
endpackage

// File: rtl/hpa_rr_arb.sv
module hpa_rr_arb #(
  parameter int NP = 6,
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    elig,
  input  logic             advance,
  output logic [NP-1:0]    grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any
);
  logic [IDX_W-1:0] ptr;
  logic [hpa_pkg::MAX_PORTS-1:0] wide;
  int sel;

  always_comb begin
    wide = '0;
    wide[NP-1:0] = elig;
    sel = hpa_pkg::rr_select(wide, int'(ptr));
    any = (sel >= 0);
    grant_idx = any ? IDX_W'(sel) : '0;
    grant = '0;
    if (any) grant[grant_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (advance) ptr <= (grant_idx == IDX_W'(NP - 1)) ? '0 : grant_idx + 1'b1;
  end

  // R8: position held while nothing is taken
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr)) else $error("pointer moved without a grant");
  // R3: pointer always lands just past the previous grant
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance && (grant_idx != IDX_W'(NP - 1)) |=> ptr == $past(grant_idx) + 1'b1)
    else $error("pointer not past last grant");
endmodule

// File: rtl/hpa_tag_fifo.sv
module hpa_tag_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_tag,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("tag queue overflow");
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("response with no outstanding read");
  // R10: simultaneous push and pop keep the count
  assert_duplex_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(count)) else $error("count moved on push+pop");
endmodule

// File: rtl/hpa_rsp_router.sv
module hpa_rsp_router #(
  parameter int NP = 6,
  parameter int DW = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [IDX_W-1:0] dest,
  output logic [NP-1:0]    out_valid,
  output logic [DW-1:0]    out_data
);
  logic [NP-1:0] sel_next;

  always_comb begin
    sel_next = '0;
    if (in_valid) sel_next[dest] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= sel_next;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_rsp_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid)) else $error("response to several ports");
  assert_rsp_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(out_valid) == 1) else $error("response pulse missing");
endmodule

// File: rtl/heap_req_arbiter.sv
module heap_req_arbiter #(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int RD_DEPTH = 8,
  localparam int NP = 2 * NUM_CORES + 2,
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        req_valid,
  output logic [NP-1:0]        req_ready,
  input  logic [NP-1:0]        req_we,
  input  logic [NP*ADDR_W-1:0] req_addr,
  input  logic [NP*DATA_W-1:0] req_wdata,
  output logic [NP-1:0]        rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [DATA_W-1:0]    mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [DATA_W-1:0]    mem_rsp_rdata
);
  // R1: core k fetch = 2k, operand = 2k+1, dma = NP-2, collector = NP-1
  logic [NP-1:0]    elig, grant;
  logic [IDX_W-1:0] grant_idx, head_tag;
  logic             any_elig, fire, rd_push, tags_full, tags_empty;

  assign elig = req_valid & (req_we | {NP{~tags_full}});
  assign fire = any_elig & mem_req_ready;
  assign rd_push = fire & ~req_we[grant_idx];

  hpa_rr_arb #(.NP(NP)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .advance(fire),
    .grant(grant), .grant_idx(grant_idx), .any(any_elig)
  );

  hpa_tag_fifo #(.DEPTH(RD_DEPTH), .W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .push(rd_push), .push_tag(grant_idx),
    .pop(mem_rsp_valid), .head(head_tag), .empty(tags_empty), .full(tags_full)
  );

  hpa_rsp_router #(.NP(NP), .DW(DATA_W), .IDX_W(IDX_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .in_valid(mem_rsp_valid), .in_data(mem_rsp_rdata),
    .dest(head_tag), .out_valid(rsp_valid), .out_data(rsp_rdata)
  );

  always_comb begin
    req_ready     = grant & {NP{mem_req_ready}};
    mem_req_valid = any_elig;
    mem_req_we    = req_we[grant_idx];
    mem_req_addr  = req_addr[grant_idx*ADDR_W +: ADDR_W];
    mem_req_wdata = req_wdata[grant_idx*DATA_W +: DATA_W];
  end

  assert_grant_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0) else $error("grant to idle port");
  assert_grant_needs_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_ready |-> req_ready == '0) else $error("grant while memory busy");
  assert_read_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tags_full |-> !(mem_req_valid && mem_req_ready && !mem_req_we))
    else $error("read issued with full tag queue");
  assert_rsp_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !tags_empty) else $error("untagged response");
endmodule

// File: tb/heap_req_arbiter_tb.sv
module heap_req_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NP = 2 * NC + 2;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0, req_ready, req_we = '0, rsp_valid;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata, mem_req_wdata, mem_rsp_rdata = '0;
  logic mem_req_valid, mem_req_we, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_req_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  heap_req_arbiter #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .RD_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // bench model state
  bit p_val[NP];
  bit p_we[NP];
  logic [AW-1:0] p_addr[NP];
  logic [DW-1:0] p_wd[NP];
  int bptr = 0, outstanding = 0;
  int mq_port[$];
  logic [AW-1:0] mq_addr[$];
  bit exp_pend = 0;
  int exp_port = 0;
  logic [DW-1:0] exp_data = '0;
  int saw_full = 0, saw_wr_full = 0, saw_pipe = 0, saw_duplex = 0;

  function automatic logic [DW-1:0] mem_model(input logic [AW-1:0] a);
    return {a ^ 16'h3c5a, ~a} + 32'h0101_0000;
  endfunction

  // round-robin restated as a modular scan
  function automatic int expect_pick(input bit el[NP], input int from);
    for (int k = 0; k < NP; k++) begin
      if (el[(from + k) % NP]) return (from + k) % NP;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int pv, input int pw, input int pr, input int ps);
    bit drove;
    int rp;
    logic [DW-1:0] rd;
    bit el[NP];
    int e;
    logic [NP-1:0] exp_rdy, exp_rsp;
    @(posedge clk); #1;
    for (int i = 0; i < NP; i++) begin
      if (!p_val[i] && ($urandom % 100) < pv) begin
        p_val[i] = 1;
        p_we[i] = ($urandom % 100) < pw;
        p_addr[i] = AW'($urandom);
        p_wd[i] = $urandom;
      end
      req_valid[i] = p_val[i];
      req_we[i] = p_we[i];
      req_addr[i*AW +: AW] = p_addr[i];
      req_wdata[i*DW +: DW] = p_wd[i];
    end
    mem_req_ready = ($urandom % 100) < pr;
    drove = 0;
    if (mq_port.size() > 0 && ($urandom % 100) < ps) begin
      drove = 1;
      rp = mq_port.pop_front();
      rd = mem_model(mq_addr.pop_front());
      mem_rsp_valid = 1;
      mem_rsp_rdata = rd;
    end else begin
      mem_rsp_valid = 0;
      mem_rsp_rdata = $urandom;
    end
    @(negedge clk);
    for (int i = 0; i < NP; i++) el[i] = p_val[i] && (p_we[i] || outstanding < DEPTH);
    e = expect_pick(el, bptr);
    chk(mem_req_valid == (e >= 0), "R9", "mem_req_valid", 64'(mem_req_valid), 64'(e >= 0));
    exp_rdy = '0;
    if (e >= 0 && mem_req_ready) exp_rdy[e] = 1'b1;
    chk(req_ready == exp_rdy, "R2 R3 R5 R8", "req_ready", 64'(req_ready), 64'(exp_rdy));
    if (outstanding == DEPTH) saw_full++;
    if (e >= 0 && mem_req_ready) begin
      chk(mem_req_we == p_we[e] && mem_req_addr == p_addr[e] &&
          (!p_we[e] || mem_req_wdata == p_wd[e]), "R1 R2", "forwarded fields",
          64'({mem_req_we, mem_req_addr}), 64'({p_we[e], p_addr[e]}));
      if (p_we[e] && outstanding == DEPTH) saw_wr_full++;
      if (!p_we[e]) begin
        if (outstanding > 0) saw_pipe++;
        if (drove) saw_duplex++;
        mq_port.push_back(e);
        mq_addr.push_back(p_addr[e]);
        outstanding++;
      end
      p_val[e] = 0;
      bptr = (e + 1) % NP;
    end
    exp_rsp = '0;
    if (exp_pend) exp_rsp[exp_port] = 1'b1;
    chk(rsp_valid == exp_rsp, "R6", "rsp_valid", 64'(rsp_valid), 64'(exp_rsp));
    if (exp_pend) chk(rsp_rdata == exp_data, "R1 R6", "rsp_rdata", 64'(rsp_rdata), 64'(exp_data));
    exp_pend = drove;
    if (drove) begin
      exp_port = rp;
      exp_data = rd;
      outstanding--;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NP; i++) p_val[i] = 0;
    // R7: quiet outputs during reset
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid == '0 && req_ready == '0 && !mem_req_valid, "R7", "reset outputs",
          64'({rsp_valid, req_ready}), 64'd0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    // R7 R4 R5: all ports read at once; search starts at 0, queue fills to 8, writes pass
    repeat (30) step(100, 30, 100, 0);
    // R8: memory refuses requests, responses still drain
    repeat (20) step(80, 50, 0, 60);
    // mixed random traffic
    repeat (3000) step(60, 40, 70, 50);
    // drain
    repeat (40) step(0, 0, 100, 100);
    chk(outstanding == 0 && mq_port.size() == 0, "R6", "all reads answered",
        64'(outstanding), 64'd0);
    chk(saw_full > 0, "R5", "queue reached full", 64'(saw_full), 64'd1);
    chk(saw_wr_full > 0, "R5", "write granted while full", 64'(saw_wr_full), 64'd1);
    chk(saw_pipe > 0, "R4", "read issued with reads pending", 64'(saw_pipe), 64'd1);
    chk(saw_duplex > 0, "R10", "issue and retire same cycle", 64'(saw_duplex), 64'd1);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule